// File: doc/BRIEF.md
# Coprocessor Operand Transfer Sequencer

This block runs on the main-processor side. It carries out a coprocessor response in which the coprocessor supplies the memory address itself. The main side does not compute it. A 16-bit response word is presented with a one-cycle `start` pulse, together with a flag that says whether the current instruction is of the conditional category. The sequencer checks the word and then reads a 32-bit address from the coprocessor's operand-address register. After that it moves the operand, 0 to 255 bytes, between memory and the coprocessor's operand register.

The operand moves as a series of four-byte memory cycles to ascending addresses. When the length is not a multiple of four, one shorter cycle at the end carries the last one to three bytes. Every memory cycle is an ordinary cycle, so the bus may be handed over between any two of them. The fetched address is held only in the sequencer's own working register. A conditional-category instruction whose response word has its acknowledge bit clear is refused: no transfer happens and a protocol-violation pulse is raised.

Top module: `cp_xfer_seq`

## Requirements
- R1: While `rst` is high and after it is released, `done`, `proto_viol`, `mem_req`, `cr_req` and `busy` are low until a word is accepted.
- R2: Response-word fields are decoded as: bit 15 acknowledge (CA), bit 13 direction (DR), bits 7..0 length in bytes. A word whose bits 12..8 are not 00101 is ignored: no access, no `done` and no `proto_viol` follow.
- R3: After a word is accepted, the first access is one read of the operand-address register (`cr_sel`=0, `cr_we`=0), and it comes before any memory cycle.
- R4: Memory cycles start at the fetched address and ascend. After each completed cycle the address advances by that cycle's byte count. There are ceil(length/4) cycles.
- R5: `mem_size` encodes the byte count (0 = four bytes, 1, 2, 3 = that many bytes). Only the final cycle may be shorter than four bytes, and its size equals length mod 4. Memory outside the operand is untouched.
- R6: With DR=0 each memory read is followed by one write of the same data to the operand register (`cr_sel`=1, `cr_we`=1). The operand register is not read.
- R7: With DR=1 each operand-register read is followed by one memory write of that data. Byte i of a cycle travels on data bits 8i+7..8i.
- R8: A conditional-category word with CA=0 gives a one-cycle `proto_viol` pulse and no register or memory access and no `done`. With CA=0 outside the conditional category, the transfer runs normally.
- R9: `mem_fc` is 5 (supervisor data) when `sup_bit` was 1 at acceptance and 1 (user data) when it was 0. Changes of `sup_bit` later in the transfer have no effect.
- R10: A length of 0 performs the address fetch, makes no memory cycle and then raises `done`.
- R11: `done` is a single-cycle pulse after the last access. A `start` arriving while `busy` is ignored.
- R12: A request (`mem_req` or `cr_req`) is held with stable address, size and direction until its ready input is seen. Each transfer completes exactly once under wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Present `prim_word` for acceptance |
| prim_word | input | 16 | Coprocessor response word |
| cond_cat | input | 1 | Current instruction is of the conditional category |
| sup_bit | input | 1 | Status-register supervisor bit |
| cr_req | output | 1 | Coprocessor register access request |
| cr_sel | output | 1 | 0 = operand-address register, 1 = operand register |
| cr_we | output | 1 | 1 = write to the coprocessor register |
| cr_wdata | output | 32 | Data written to the operand register |
| cr_rdata | input | 32 | Data read from the coprocessor register |
| cr_rdy | input | 1 | Coprocessor access complete |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Byte count code (0 = 4) |
| mem_fc | output | 3 | Function code (1 user data, 5 supervisor data) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_rdy | input | 1 | Memory cycle complete |
| busy | output | 1 | A word is being processed |
| done | output | 1 | Transfer finished pulse |
| proto_viol | output | 1 | Protocol-violation pulse |

## Verification
The hardest situation to reach is a tail cycle that meets a wait state while the supervisor bit changes and a second `start` arrives mid-transfer. If any of these is handled wrongly, a write spills past the operand or the address space changes. The directed tasks get there by holding `mem_rdy` and `cr_rdy` back for a set number of cycles. In the same runs they flip `sup_bit` right after acceptance and pulse a violating word while the sequencer is busy. Lengths 7, 5, 6 and 255 cover every tail size. The byte just past the operand is checked to be unchanged.

// File: rtl/cp_xfer_pkg.sv
`timescale 1ns/1ps
package cp_xfer_pkg;
  localparam logic [4:0] PRIM_TAKE_XFER = 5'b00101;
  localparam logic [2:0] FC_USR_DATA    = 3'd1;
  localparam logic [2:0] FC_SUP_DATA    = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_FADR, S_MRD, S_CWR, S_CRD, S_MWR, S_FIN, S_VIOL
  } seq_state_t;

  typedef struct packed {
    logic       ca;
    logic       dr;
    logic       type_ok;
    logic [7:0] len;
  } prim_fields_t;
endpackage

// File: rtl/cp_prim_decode.sv
`timescale 1ns/1ps
module cp_prim_decode
  import cp_xfer_pkg::*;
(
  input  logic [15:0]  word,
  output prim_fields_t fields
);
  // the PC bit belongs to other handling stages
  logic unused_pc;
  assign unused_pc = word[14];

  always_comb begin
    fields.ca      = word[15];
    fields.dr      = word[13];
    fields.type_ok = (word[12:8] == PRIM_TAKE_XFER);
    fields.len     = word[7:0];
  end
endmodule

// File: rtl/cp_beat_size.sv
`timescale 1ns/1ps
module cp_beat_size #(
  parameter int LEN_W      = 8,
  parameter int BEAT_BYTES = 4
) (
  input  logic [LEN_W-1:0]              rem,
  output logic [$clog2(BEAT_BYTES):0]   nbytes,
  output logic [$clog2(BEAT_BYTES)-1:0] size_code
);
  localparam int SIZE_W = $clog2(BEAT_BYTES);
  localparam int CNT_W  = SIZE_W + 1;

  logic full;
  assign full      = rem >= LEN_W'(BEAT_BYTES);
  assign nbytes    = full ? CNT_W'(BEAT_BYTES) : CNT_W'(rem[SIZE_W-1:0]);
  assign size_code = full ? '0 : rem[SIZE_W-1:0];
endmodule

// File: rtl/cp_xfer_seq.sv
`timescale 1ns/1ps
module cp_xfer_seq
  import cp_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       prim_word,
  input  logic              cond_cat,
  input  logic              sup_bit,
  output logic              cr_req,
  output logic              cr_sel,
  output logic              cr_we,
  output logic [DATA_W-1:0] cr_wdata,
  input  logic [DATA_W-1:0] cr_rdata,
  input  logic              cr_rdy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [$clog2(DATA_W/8)-1:0] mem_size,
  output logic [2:0]        mem_fc,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic              busy,
  output logic              done,
  output logic              proto_viol
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int SIZE_W     = $clog2(BEAT_BYTES);
  localparam int CNT_W      = SIZE_W + 1;

  seq_state_t        st;
  prim_fields_t      pf;
  logic [DATA_W-1:0] addr_q, data_q;
  logic [LEN_W-1:0]  rem_q;
  logic              dr_q;
  logic [2:0]        fc_q;
  logic [CNT_W-1:0]  nbytes;
  logic [SIZE_W-1:0] size_code;

  cp_prim_decode u_dec (.word(prim_word), .fields(pf));

  cp_beat_size #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_beat (
    .rem(rem_q), .nbytes(nbytes), .size_code(size_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      rem_q  <= '0;
      dr_q   <= 1'b0;
      fc_q   <= FC_USR_DATA;
    end else begin
      case (st)
        S_IDLE: if (start && pf.type_ok) begin
          dr_q  <= pf.dr;
          rem_q <= LEN_W'(pf.len);
          fc_q  <= sup_bit ? FC_SUP_DATA : FC_USR_DATA;
          st    <= (cond_cat && !pf.ca) ? S_VIOL : S_FADR;
        end
        S_FADR: if (cr_rdy) begin
          addr_q <= cr_rdata;
          if (rem_q == '0) st <= S_FIN;
          else             st <= dr_q ? S_CRD : S_MRD;
        end
        S_MRD: if (mem_rdy) begin
          data_q <= mem_rdata;
          addr_q <= addr_q + DATA_W'(nbytes);
          rem_q  <= rem_q - LEN_W'(nbytes);
          st     <= S_CWR;
        end
        S_CWR: if (cr_rdy) st <= (rem_q == '0) ? S_FIN : S_MRD;
        S_CRD: if (cr_rdy) begin
          data_q <= cr_rdata;
          st     <= S_MWR;
        end
        S_MWR: if (mem_rdy) begin
          addr_q <= addr_q + DATA_W'(nbytes);
          rem_q  <= rem_q - LEN_W'(nbytes);
          st     <= (rem_q == LEN_W'(nbytes)) ? S_FIN : S_CRD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req    = (st == S_MRD) || (st == S_MWR);
  assign mem_we     = (st == S_MWR);
  assign mem_addr   = addr_q;
  assign mem_size   = size_code;
  assign mem_fc     = fc_q;
  assign mem_wdata  = data_q;
  assign cr_req     = (st == S_FADR) || (st == S_CRD) || (st == S_CWR);
  assign cr_sel     = (st != S_FADR);
  assign cr_we      = (st == S_CWR);
  assign cr_wdata   = data_q;
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
  assign proto_viol = (st == S_VIOL);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we));
  // R12
  cr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cr_req && !cr_rdy |=> cr_req && $stable(cr_sel) && $stable(cr_we));
  // R8
  viol_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    proto_viol |-> !mem_req && !cr_req && !done);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  fc_space_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_fc == FC_SUP_DATA) || (mem_fc == FC_USR_DATA));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_rdy && (mem_size == '0) |=> mem_addr == $past(mem_addr) + DATA_W'(BEAT_BYTES));
endmodule

// File: tb/cp_xfer_seq_test.sv
`timescale 1ns/1ps
module cp_xfer_seq_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, start, cond_cat, sup_bit;
  logic [15:0] prim_word;
  logic        cr_req, cr_sel, cr_we, cr_rdy;
  logic [31:0] cr_wdata, cr_rdata;
  logic        mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic [2:0]  mem_fc;
  logic        busy, done, proto_viol;

  cp_xfer_seq uut (
    .clk(clk), .rst(rst), .start(start), .prim_word(prim_word),
    .cond_cat(cond_cat), .sup_bit(sup_bit),
    .cr_req(cr_req), .cr_sel(cr_sel), .cr_we(cr_we), .cr_wdata(cr_wdata),
    .cr_rdata(cr_rdata), .cr_rdy(cr_rdy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_fc(mem_fc), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .busy(busy), .done(done), .proto_viol(proto_viol)
  );

  int nchk = 0, nerr = 0;
  int mem_wait = 0, cr_wait = 0;
  logic [31:0] cp_addr_val = 32'h0;
  logic [7:0]  bmem [0:1023];
  logic [31:0] ml_addr [0:79];
  logic [1:0]  ml_size [0:79];
  logic [2:0]  ml_fc   [0:79];
  logic        ml_we   [0:79];
  logic [31:0] cw_log  [0:79];
  int mem_n, af_n, opr_n, cw_n, done_n, viol_n, bad_af;
  bit mem_before_af;

  function automatic logic [7:0] pat(int a);
    return 8'(a) ^ 8'h3C;
  endfunction

  function automatic logic [31:0] op_word(int k);
    return 32'h5A0F_3C00 ^ (32'(k) * 32'h0101_0101) ^ 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    int cnt = 0;
    mem_rdy = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_rdy) mem_rdy = 1'b0;
      else if (mem_req) begin
        if (cnt >= mem_wait) begin
          int n;
          cnt = 0;
          n = (mem_size == 2'd0) ? 4 : int'(mem_size);
          if (af_n == 0) mem_before_af = 1'b1;
          if (mem_n < 80) begin
            ml_addr[mem_n] = mem_addr; ml_size[mem_n] = mem_size;
            ml_fc[mem_n] = mem_fc; ml_we[mem_n] = mem_we;
          end
          mem_rdata = '0;
          for (int i = 0; i < n; i++) begin
            if (mem_we) bmem[10'(mem_addr + 32'(i))] = mem_wdata[8*i +: 8];
            else mem_rdata[8*i +: 8] = bmem[10'(mem_addr + 32'(i))];
          end
          mem_n++;
          mem_rdy = 1'b1;
        end else cnt++;
      end
    end
  end

  // coprocessor register responder
  initial begin
    int cnt = 0;
    cr_rdy = 1'b0; cr_rdata = '0;
    forever begin
      @(negedge clk);
      if (cr_rdy) cr_rdy = 1'b0;
      else if (cr_req) begin
        if (cnt >= cr_wait) begin
          cnt = 0;
          if (!cr_sel) begin
            if (cr_we) bad_af++;
            cr_rdata = cp_addr_val; af_n++;
          end else if (!cr_we) begin
            cr_rdata = op_word(opr_n); opr_n++;
          end else begin
            if (cw_n < 80) cw_log[cw_n] = cr_wdata;
            cw_n++;
          end
          cr_rdy = 1'b1;
        end else cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) done_n++;
      if (proto_viol) viol_n++;
    end
  end

  task automatic clear_logs();
    mem_n = 0; af_n = 0; opr_n = 0; cw_n = 0; done_n = 0; viol_n = 0; bad_af = 0;
    mem_before_af = 1'b0;
    for (int a = 0; a < 1024; a++) bmem[a] = pat(a);
  endtask

  task automatic issue(input logic [15:0] w, input bit cond, input bit sup);
    @(negedge clk);
    prim_word = w; cond_cat = cond; sup_bit = sup; start = 1'b1;
    @(negedge clk);
    start = 1'b0; sup_bit = ~sup;
  endtask

  task automatic test_reset();
    rst = 1'b1; start = 1'b0; prim_word = '0; cond_cat = 1'b0; sup_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !proto_viol && !mem_req && !cr_req && !busy, "R1 in reset",
        {27'd0, done, proto_viol, mem_req, cr_req, busy}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!done && !proto_viol && !mem_req && !cr_req && !busy, "R1 after reset",
        {27'd0, done, proto_viol, mem_req, cr_req, busy}, 32'd0);
  endtask

  task automatic run_case(input bit ca, input bit cond, input bit dr, input bit sup,
                          input logic [7:0] len, input logic [31:0] base,
                          input int mw, input int cw, input bit poke);
    int t = 0;
    int beats;
    bit viol_exp;
    logic [2:0] fc_exp;
    clear_logs();
    mem_wait = mw; cr_wait = cw; cp_addr_val = base;
    issue({ca, 1'b0, dr, 5'b00101, len}, cond, sup);
    if (poke) begin
      prim_word = {1'b0, 1'b0, 1'b0, 5'b00101, 8'd4}; cond_cat = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_n == 0 && viol_n == 0 && t < 4000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(t < 4000, "R11 completion", 32'(t), 32'd4000);
    viol_exp = cond && !ca;
    beats = (int'(len) + 3) / 4;
    fc_exp = sup ? 3'd5 : 3'd1;
    if (viol_exp) begin
      chk(viol_n == 1, "R8 pulse", 32'(viol_n), 32'd1);
      chk(done_n == 0 && mem_n == 0 && af_n == 0 && opr_n == 0 && cw_n == 0, "R8 no access",
          32'(mem_n + af_n + opr_n + cw_n + done_n), 32'd0);
      return;
    end
    chk(done_n == 1, "R11 single done", 32'(done_n), 32'd1);
    chk(viol_n == 0, poke ? "R11 busy start ignored" : "R8 no violation", 32'(viol_n), 32'd0);
    chk(af_n == 1 && bad_af == 0, "R3 address fetch", 32'(af_n), 32'd1);
    chk(!mem_before_af, "R3 order", 32'(mem_before_af), 32'd0);
    chk(mem_n == beats, (mw > 0) ? "R12 cycle count" : "R4 cycle count", 32'(mem_n), 32'(beats));
    if (len == 8'd0) chk(mem_n == 0, "R10 no memory cycle", 32'(mem_n), 32'd0);
    for (int k = 0; k < beats && k < mem_n; k++) begin
      int n = (int'(len) - 4*k >= 4) ? 4 : int'(len) - 4*k;
      chk(ml_addr[k] == base + 32'(4*k), "R4 address", ml_addr[k], base + 32'(4*k));
      chk(ml_size[k] == 2'(n), "R5 size", 32'(ml_size[k]), 32'(2'(n)));
      chk(ml_fc[k] == fc_exp, "R9 function code", 32'(ml_fc[k]), 32'(fc_exp));
      chk(ml_we[k] == dr, dr ? "R7 write" : "R6 read", 32'(ml_we[k]), 32'(dr));
      if (!dr && k < cw_n) begin
        logic [31:0] e = '0;
        for (int i = 0; i < n; i++) e[8*i +: 8] = pat(int'(base) + 4*k + i);
        chk(cw_log[k] == e, "R6 data", cw_log[k], e);
      end
    end
    if (!dr) begin
      chk(cw_n == beats && opr_n == 0, "R6 operand writes", 32'(cw_n), 32'(beats));
    end else begin
      chk(opr_n == beats && cw_n == 0, "R7 operand reads", 32'(opr_n), 32'(beats));
      for (int j = 0; j < int'(len); j++) begin
        logic [31:0] w = op_word(j / 4);
        logic [7:0]  e = w[8*(j%4) +: 8];
        logic [7:0]  a = bmem[10'(base + 32'(j))];
        chk(a == e, "R7 byte", 32'(a), 32'(e));
      end
      begin
        logic [7:0] a = bmem[10'(base + 32'(len))];
        logic [7:0] e = pat(int'(base) + int'(len));
        chk(a == e, "R5 beyond operand", 32'(a), 32'(e));
      end
    end
  endtask

  task automatic test_bad_type();
    clear_logs();
    issue({1'b1, 1'b0, 1'b0, 5'b00110, 8'd8}, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(done_n == 0 && viol_n == 0 && af_n == 0 && mem_n == 0, "R2 wrong type ignored",
        32'(done_n + viol_n + af_n + mem_n), 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL R11 watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    test_reset();
    run_case(1'b1, 1'b0, 1'b0, 1'b1, 8'd8,   32'h100, 0, 0, 1'b0); // R6 R9 R2
    run_case(1'b1, 1'b0, 1'b0, 1'b0, 8'd7,   32'h140, 2, 1, 1'b0); // R5 tail 3, R12
    run_case(1'b1, 1'b1, 1'b1, 1'b1, 8'd5,   32'h180, 1, 2, 1'b0); // R7 tail 1
    run_case(1'b0, 1'b0, 1'b1, 1'b0, 8'd6,   32'h1C0, 0, 0, 1'b0); // R8 CA=0 outside conditional, tail 2
    run_case(1'b1, 1'b0, 1'b0, 1'b1, 8'd0,   32'h200, 0, 1, 1'b0); // R10
    run_case(1'b0, 1'b1, 1'b0, 1'b1, 8'd12,  32'h240, 0, 0, 1'b0); // R8
    run_case(1'b1, 1'b1, 1'b1, 1'b0, 8'd255, 32'h280, 1, 0, 1'b1); // R4 long, R11 busy start
    run_case(1'b1, 1'b0, 1'b0, 1'b0, 8'd3,   32'h3F0, 3, 3, 1'b0); // R5 short only
    test_bad_type();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule